// File: doc/BRIEF.md
# Line-Straddling Reference Resolver

This block sits in front of a cache tag store and turns one memory reference, given as a byte address and a byte count, into a single hit or miss outcome. It works out the first and the last cache line the reference touches. A reference inside one line costs one tag-store lookup, and that lookup's outcome is passed through unchanged. A reference that runs into the following line costs two lookups, strictly one after the other, and their outcomes are merged so that the whole reference counts as one access.

Both lines of a straddling reference are always presented to the tag store, even when the first one has already missed, because each lookup also updates that set's replacement order. Every lookup carries its own set index, taken from the low bits of its block number, and its own tag, which is the full block number. A reference that would span more than two lines, a zero-byte reference, or one whose second line would run past the top of the address space is rejected. It issues no lookup, returns a miss, and sets an error flag that stays set until reset.

Top module: `line_ref_resolver`

## Requirements
- R1: While and right after reset, `req_ready` is 1 and `res_valid`, `lk_valid` and `err_flag` are 0.
- R2: A reference whose first byte and last byte (address + size − 1) lie in the same block (address shifted right by log2 of the line size) issues exactly one lookup. Its `lk_tag` is that block number, its `lk_set` is the low log2(SETS) bits of the block number, and `res_miss` equals that lookup's `lk_rsp_miss`.
- R3: A reference whose last block is the first block plus one issues exactly two lookups: first block, then first block plus one. Each carries the set index and tag of its own block.
- R4: For a two-line reference `res_miss` is 1 if either lookup missed, and 0 only when both hit.
- R5: The second lookup of a two-line reference is issued even when the first lookup returned a miss.
- R6: The second lookup is issued only after the response to the first lookup has arrived, never before.
- R7: A reference of size 0, one spanning three or more lines, or one whose second block would pass the highest block number issues no lookup. It returns `res_valid` with `res_miss` = 1 in the cycle after it is accepted, and sets `err_flag`.
- R8: `err_flag` stays 1 until reset, and references made after the error are still resolved normally.
- R9: `req_ready` is 0 from the cycle after a valid reference is accepted until its last lookup response, and no lookup is presented while `req_ready` is 1.
- R10: For a reference that makes lookups, `res_valid` is a one-cycle pulse in the cycle after the last lookup response. It is never high in a cycle in which `lk_valid` is high.
- R11: `lk_valid` is a one-cycle pulse for each lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Reference offered; taken when `req_ready` is 1 |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | SIZE_W | Number of bytes referenced |
| req_ready | output | 1 | Resolver idle and able to take a reference |
| lk_valid | output | 1 | One-cycle lookup strobe to the tag store |
| lk_set | output | SET_W | Set index of the looked-up block |
| lk_tag | output | BLK_W | Tag (full block number) of the looked-up block |
| lk_rsp_valid | input | 1 | Tag store response strobe, at least one cycle after `lk_valid` |
| lk_rsp_miss | input | 1 | 1 when the looked-up block missed |
| res_valid | output | 1 | One-cycle strobe carrying the merged outcome |
| res_miss | output | 1 | 1 when the reference as a whole missed |
| err_flag | output | 1 | Sticky flag for a rejected reference |

## Verification
A lost or stale merge bit shows up as a wrong `res_miss` on the very next two-line reference whose first line missed and second hit. That is why the miss patterns of both lines are varied in every combination. A sequencer stuck in a waiting state shows up at once as `req_ready` never returning and a missing result pulse. A wrong block for the second line shows up in the second `lk_tag` and `lk_set` of the same reference. Random addresses and sizes push many references across line edges and past the two-line limit, so that decode faults show up as lookup counts that do not match the expected count.

// File: rtl/ref_pkg.sv
package ref_pkg;

  // How many cache lines a reference covers, as seen by the decoder.
  typedef enum logic [1:0] {
    SPAN_ONE = 2'd0,
    SPAN_TWO = 2'd1,
    SPAN_BAD = 2'd2
  } span_e;

  // Sequencer states.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_WAIT2 = 2'd2
  } seq_e;

endpackage

// File: rtl/ref_span_decode.sv
module ref_span_decode
  import ref_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  parameter int OFFS_W = 4,
  localparam int BLK_W = ADDR_W - OFFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [BLK_W-1:0]  blk_first,
  output logic [BLK_W-1:0]  blk_second,
  output span_e             kind
);

  logic [ADDR_W:0] addr_ext;
  logic [ADDR_W:0] size_ext;
  logic [BLK_W:0]  first_ext;
  logic [BLK_W:0]  last_ext;
  logic [BLK_W:0]  next_ext;

  always_comb begin
    addr_ext  = {1'b0, addr};
    size_ext  = {{(ADDR_W + 1 - SIZE_W){1'b0}}, size};
    first_ext = {1'b0, addr[ADDR_W-1:OFFS_W]};
    // last byte computed one bit wider so a carry out of the top is kept
    last_ext  = (BLK_W + 1)'((addr_ext + size_ext - {{ADDR_W{1'b0}}, 1'b1}) >> OFFS_W);
    next_ext  = first_ext + {{BLK_W{1'b0}}, 1'b1};
  end

  assign blk_first  = first_ext[BLK_W-1:0];
  assign blk_second = last_ext[BLK_W-1:0];

  always_comb begin
    if (size == '0) begin
      kind = SPAN_BAD;
    end else if (last_ext == first_ext) begin
      kind = SPAN_ONE;
    end else if ((last_ext == next_ext) && !last_ext[BLK_W]) begin
      kind = SPAN_TWO;
    end else begin
      kind = SPAN_BAD;
    end
  end

endmodule

// File: rtl/ref_lookup_seq.sv
module ref_lookup_seq
  import ref_pkg::*;
#(
  parameter int BLK_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  span_e            kind,
  input  logic [BLK_W-1:0] blk_first,
  input  logic [BLK_W-1:0] blk_second,
  input  logic             rsp_valid,
  output logic             req_ready,
  output logic             lk_valid,
  output logic [BLK_W-1:0] lk_blk,
  output logic             take_bad,
  output logic             rsp_first,
  output logic             rsp_final,
  output logic             final_is_second
);

  seq_e             state_q;
  logic             pair_q;
  logic [BLK_W-1:0] second_q;

  assign req_ready       = (state_q == ST_IDLE);
  assign take_bad        = req_ready && req_valid && (kind == SPAN_BAD);
  assign rsp_first       = rsp_valid && (state_q == ST_WAIT1);
  assign final_is_second = (state_q == ST_WAIT2);
  assign rsp_final       = rsp_valid &&
                           (((state_q == ST_WAIT1) && !pair_q) || (state_q == ST_WAIT2));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pair_q   <= 1'b0;
      second_q <= '0;
      lk_valid <= 1'b0;
      lk_blk   <= '0;
    end else begin
      lk_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid && (kind != SPAN_BAD)) begin
            lk_valid <= 1'b1;
            lk_blk   <= blk_first;
            pair_q   <= (kind == SPAN_TWO);
            second_q <= blk_second;
            state_q  <= ST_WAIT1;
          end
        end
        ST_WAIT1: begin
          if (rsp_valid) begin
            if (pair_q) begin
              // second line always looked up: replacement order must move
              lk_valid <= 1'b1;
              lk_blk   <= second_q;
              state_q  <= ST_WAIT2;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WAIT2: begin
          if (rsp_valid) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ref_outcome_merge.sv
module ref_outcome_merge (
  input  logic clk,
  input  logic rst,
  input  logic take_bad,
  input  logic rsp_first,
  input  logic rsp_final,
  input  logic final_is_second,
  input  logic rsp_miss,
  output logic res_valid,
  output logic res_miss,
  output logic err_flag
);

  logic acc_miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_miss_q <= 1'b0;
      res_valid  <= 1'b0;
      res_miss   <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (take_bad) begin
        res_valid <= 1'b1;
        res_miss  <= 1'b1;
        err_flag  <= 1'b1;
      end
      if (rsp_first) begin
        acc_miss_q <= rsp_miss;
      end
      if (rsp_final) begin
        res_valid <= 1'b1;
        res_miss  <= rsp_miss | (final_is_second & acc_miss_q);
      end
    end
  end

endmodule

// File: rtl/line_ref_resolver.sv
module line_ref_resolver
  import ref_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 5,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 8,
  localparam int OFFS_W = $clog2(LINE_BYTES),
  localparam int BLK_W  = ADDR_W - OFFS_W,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              req_ready,
  output logic              lk_valid,
  output logic [SET_W-1:0]  lk_set,
  output logic [BLK_W-1:0]  lk_tag,
  input  logic              lk_rsp_valid,
  input  logic              lk_rsp_miss,
  output logic              res_valid,
  output logic              res_miss,
  output logic              err_flag
);

  span_e            kind;
  logic [BLK_W-1:0] blk_first;
  logic [BLK_W-1:0] blk_second;
  logic [BLK_W-1:0] lk_blk;
  logic             take_bad;
  logic             rsp_first;
  logic             rsp_final;
  logic             final_is_second;

  ref_span_decode #(
    .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W),
    .OFFS_W(OFFS_W)
  ) u_decode (
    .addr      (req_addr),
    .size      (req_size),
    .blk_first (blk_first),
    .blk_second(blk_second),
    .kind      (kind)
  );

  ref_lookup_seq #(
    .BLK_W(BLK_W)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .kind           (kind),
    .blk_first      (blk_first),
    .blk_second     (blk_second),
    .rsp_valid      (lk_rsp_valid),
    .req_ready      (req_ready),
    .lk_valid       (lk_valid),
    .lk_blk         (lk_blk),
    .take_bad       (take_bad),
    .rsp_first      (rsp_first),
    .rsp_final      (rsp_final),
    .final_is_second(final_is_second)
  );

  ref_outcome_merge u_merge (
    .clk            (clk),
    .rst            (rst),
    .take_bad       (take_bad),
    .rsp_first      (rsp_first),
    .rsp_final      (rsp_final),
    .final_is_second(final_is_second),
    .rsp_miss       (lk_rsp_miss),
    .res_valid      (res_valid),
    .res_miss       (res_miss),
    .err_flag       (err_flag)
  );

  assign lk_tag = lk_blk;

  generate
    if (SETS > 1) begin : g_set_bits
      assign lk_set = lk_blk[SET_W-1:0];
    end else begin : g_one_set
      assign lk_set = '0;
    end
  endgenerate

endmodule

// File: rtl/line_ref_resolver_chk.sv
module line_ref_resolver_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic lk_valid,
  input logic lk_rsp_valid,
  input logic res_valid,
  input logic res_miss,
  input logic err_flag
);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R8

  AST_LK_PULSE: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> !lk_valid); // R11

  AST_NO_LK_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !lk_valid); // R9

  AST_ERR_GIVES_MISS: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> (res_valid && res_miss)); // R7

  AST_RES_NOT_WITH_LK: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> !res_valid); // R10

  AST_SECOND_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !$past(req_ready)) |-> $past(lk_rsp_valid)); // R6

endmodule

bind line_ref_resolver line_ref_resolver_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .lk_valid    (lk_valid),
  .lk_rsp_valid(lk_rsp_valid),
  .res_valid   (res_valid),
  .res_miss    (res_miss),
  .err_flag    (err_flag)
);

// File: tb/line_ref_resolver_bench.sv
`timescale 1ns/1ps
module line_ref_resolver_bench;

  localparam int ADDR_W = 32;
  localparam int SIZE_W = 5;
  localparam int LINE_BYTES = 16;
  localparam int SETS = 8;
  localparam int OFFS_W = 4;
  localparam int BLK_W = ADDR_W - OFFS_W;
  localparam int SET_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic              req_ready;
  logic              lk_valid;
  logic [SET_W-1:0]  lk_set;
  logic [BLK_W-1:0]  lk_tag;
  logic              lk_rsp_valid = 1'b0;
  logic              lk_rsp_miss = 1'b0;
  logic              res_valid;
  logic              res_miss;
  logic              err_flag;

  always #2.5 clk = ~clk;

  line_ref_resolver #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)
  ) u_line_ref_resolver (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_ready(req_ready),
    .lk_valid(lk_valid), .lk_set(lk_set), .lk_tag(lk_tag),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_miss(lk_rsp_miss),
    .res_valid(res_valid), .res_miss(res_miss), .err_flag(err_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // tag-store responder and lookup log
  logic [BLK_W-1:0] log_tag [0:4095];
  logic [SET_W-1:0] log_set [0:4095];
  int               log_lcyc [0:4095];
  int               log_rcyc [0:4095];
  int  lk_total = 0;
  int  base = 0;
  bit  miss_plan [0:1];
  int  pend = 0;
  int  pidx = 0;
  bit  pmiss = 0;
  int  rsp_delay = 1;

  always @(negedge clk) begin
    lk_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        lk_rsp_valid = 1'b1;
        lk_rsp_miss  = pmiss;
        log_rcyc[pidx] = cyc;
      end
    end
    if (lk_valid) begin
      pidx = lk_total;
      log_tag[pidx[11:0]] = lk_tag;
      log_set[pidx[11:0]] = lk_set;
      log_lcyc[pidx[11:0]] = cyc;
      pmiss = ((lk_total - base) < 2) ? miss_plan[lk_total - base] : 1'b1;
      pend = rsp_delay;
      lk_total = lk_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 = one line, 1 = two lines, 2 = rejected
  function automatic int exp_kind(input logic [31:0] a, input logic [4:0] s);
    longint unsigned b1, b2;
    if (s == 0) return 2;
    b1 = longint'(a) >> OFFS_W;
    b2 = (longint'(a) + longint'(s) - 1) >> OFFS_W;
    if (b1 == b2) return 0;
    if (b2 == b1 + 1 && b2 < (64'd1 << BLK_W)) return 1;
    return 2;
  endfunction

  bit err_exp = 0;

  task automatic run_ref(input logic [31:0] a, input logic [4:0] s,
                         input bit m0, input bit m1, input int dly);
    int k, t0, tres, n, guard;
    bit got, exp_miss;
    logic [BLK_W-1:0] b1;
    k = exp_kind(a, s);
    b1 = a[31:OFFS_W];
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    miss_plan[0] = m0; miss_plan[1] = m1; base = lk_total; rsp_delay = dly;
    req_valid = 1'b1; req_addr = a; req_size = s; t0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (k != 2) chk(req_ready == 1'b0, "R9 busy after accept", req_ready, 0);
    guard = 0;
    while (!res_valid && guard < 50) begin @(negedge clk); guard++; end
    got = res_miss; tres = cyc;
    chk(res_valid == 1'b1, "R10 result arrives", res_valid, 1);
    n = lk_total - base;
    if (k == 2) begin
      err_exp = 1;
      chk(n == 0, "R7 no lookup on reject", n, 0);
      chk(got == 1'b1, "R7 reject reports miss", got, 1);
      chk(tres == t0 + 1, "R7 result one cycle after accept", tres, t0 + 1);
    end else if (k == 0) begin
      chk(n == 1, "R2 one lookup", n, 1);
      chk(log_tag[base[11:0]] == b1, "R2 tag", log_tag[base[11:0]], b1);
      chk(log_set[base[11:0]] == b1[SET_W-1:0], "R2 set", log_set[base[11:0]], b1[SET_W-1:0]);
      chk(got == m0, "R2 pass-through outcome", got, m0);
      chk(tres == log_rcyc[base[11:0]] + 1, "R10 result timing", tres, log_rcyc[base[11:0]] + 1);
    end else begin
      exp_miss = m0 | m1;
      chk(n == 2, m0 ? "R5 second lookup after first miss" : "R3 two lookups", n, 2);
      chk(log_tag[base[11:0]] == b1, "R3 first tag", log_tag[base[11:0]], b1);
      chk(log_tag[base[11:0]+1] == b1 + 1, "R3 second tag", log_tag[base[11:0]+1], b1 + 1);
      chk(log_set[base[11:0]+1] == SET_W'(b1 + 1), "R3 second set",
          log_set[base[11:0]+1], SET_W'(b1 + 1));
      chk(log_lcyc[base[11:0]+1] > log_rcyc[base[11:0]], "R6 second after first response",
          log_lcyc[base[11:0]+1], log_rcyc[base[11:0]] + 1);
      chk(got == exp_miss, "R4 merged outcome", got, exp_miss);
      chk(tres == log_rcyc[base[11:0]+1] + 1, "R10 result timing", tres, log_rcyc[base[11:0]+1] + 1);
    end
    chk(err_flag == err_exp, "R8 error flag", err_flag, err_exp);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 result is a pulse", res_valid, 0);
  endtask

  task automatic check_reset_state();
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(lk_valid == 1'b0, "R1 lk_valid", lk_valid, 0);
    chk(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0123));
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    // directed corners
    run_ref(32'h0000_1000, 5'd16, 1'b0, 1'b0, 1); // whole line, R2
    run_ref(32'h0000_100F, 5'd1, 1'b1, 1'b0, 2);  // last byte of line, R2
    run_ref(32'h0000_203F, 5'd2, 1'b0, 1'b0, 1);  // straddle hit/hit, R3
    run_ref(32'h0000_203F, 5'd2, 1'b1, 1'b0, 3);  // miss/hit, R5
    run_ref(32'h0000_203A, 5'd9, 1'b0, 1'b1, 1);  // hit/miss, R4
    run_ref(32'h0000_2031, 5'd31, 1'b1, 1'b1, 2); // miss/miss, R4
    run_ref(32'h0000_3008, 5'd31, 1'b0, 1'b0, 1); // three lines, R7
    run_ref(32'h0000_4000, 5'd16, 1'b1, 1'b0, 1); // after error, R8
    run_ref(32'h0000_5004, 5'd0, 1'b0, 1'b0, 1);  // size zero, R7
    run_ref(32'hFFFF_FFF8, 5'd16, 1'b0, 1'b0, 1); // wraps past top, R7

    // reset clears sticky error, R1
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; err_exp = 0;
    @(negedge clk);
    check_reset_state();

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [4:0]  s;
      a = $urandom();
      if ($urandom_range(0, 3) == 0) a[3:0] = 4'hF - 4'($urandom_range(0, 3));
      s = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(1, 16));
      run_ref(a, s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(1, 3));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule